// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the processor-facing register file of a serial port. Software reaches it over a simple 32-bit register bus in which the address is a word index. The block stores the control, baud and FIFO-control settings. It composes the status and test words from the live state of a one-character receive holding buffer and a one-character transmit hand-off. It drives a single interrupt line.

The bit-level serial engine sits outside. It delivers characters over a `rx_valid`/`rx_accept` handshake, where a break condition is flagged with `rx_break`. It takes characters over a `tx_valid`/`tx_ready` handshake.

Software can return the block to its power-up state by writing control word 2 with its reset bit cleared. The stored copy of that word always reads back with the reset bit set.

Top module: `serial_reg_front`

## Requirements
- R1: After `rst_n` low, reads return: index 0x20 = 0, 0x21 = 0x0001, 0x22 = 0x0700, 0x24 = 0, 0x25 = 0x6040, 0x26 = 0x4028, 0x2B = 4, 0x2D = 0x0060, and receive data at 0x00 = 0x4000 (error marker, bit 14).
- R2: Writes to indices 0x20, 0x21, 0x22, 0x24, 0x2A and 0x2C store only `wdata[15:0]`. A write to 0x29 stores `wdata[15:0]` into the count word read at 0x2B. Reads of 0x23 and 0x29 return 0.
- R3: Writes to 0x23, 0x2B, 0x2D and any unlisted index change nothing. Reads of any unlisted index return 0.
- R4: A write to 0x21 with bit 0 clear restores the R1 state of control 1/2/3, modulator (0x2A), count (0x2B), receive buffer and flags, and transmit hand-off. The FIFO-control (0x24) and millisecond (0x2C) words are left as they were. Control 2 then holds `wdata[15:0]` with bit 0 set.
- R5: `rx_accept` is high exactly when `rx_valid` is high, status 1 bit 9 (RRDY) is clear and no soft reset is being written. An accepted character sets status 1 bit 9 and status 2 bit 0, and clears test bit 5 (rx-empty).
- R6: A read of index 0x00 while a character is held returns the buffer with bit 15 set, then clears status 1 bit 9 and status 2 bit 0 and sets test bit 5. A read of 0x00 with nothing held returns the buffer without bit 15 and changes nothing.
- R7: A character accepted with `rx_break` high loads the break code 0x0800 (bit 11) in place of the data.
- R8: `irq` equals (status1 AND control1) restricted to bits 13 and 9. When control 1 bit 6 is set, test bit 6 (tx-empty, always 1 here) is ORed in. When control 1 bit 6 is clear, the bit 13 term is dropped.
- R9: A write to index 0x10 while control 2 bit 2 is set raises `tx_valid` with `wdata[7:0]` on `tx_data` in the next cycle. It clears status 1 bit 13 (TRDY) until `tx_ready` is seen. With control 2 bit 2 clear, the write is ignored.
- R10: Writes of ones to status 1 (0x25) and status 2 (0x26) only clear event bits, which no source sets here. The ready, idle, line-status and flag bits are unaffected.
- R11: `rdata` is loaded on the clock edge that samples `rd_en`, and it holds its value in cycles without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Character offered to serial engine |
| tx_data | output | 8 | Character to transmit |
| tx_ready | input | 1 | Engine takes the offered character |
| rx_valid | input | 1 | Engine offers a received character |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | Offered item is a break condition |
| rx_accept | output | 1 | Block takes the offered character |

## Verification
The hardest state to reach is a second character offered while the first is still unread. Here `rx_accept` must stay low and the held value must survive. The bench keeps `rx_valid` high across a full cycle after the first character lands. It then reads the buffer twice. The first read must return the data with the ready bit, and the second must return the same data without it. A soft reset issued while a character is held is driven the same way. This shows that the receive flags fall back to empty with only a register write.

// File: rtl/srf_pkg.sv
// Package: shared constants of the serial register front end.
// Assumes a word-indexed register bus and 16-bit register contents.
package srf_pkg;
    localparam int REG_W = 16;
    localparam int IDX_W = 6;

    // word indices
    localparam logic [IDX_W-1:0] IX_RXD  = 6'h00;
    localparam logic [IDX_W-1:0] IX_TXD  = 6'h10;
    localparam logic [IDX_W-1:0] IX_CR1  = 6'h20;
    localparam logic [IDX_W-1:0] IX_CR2  = 6'h21;
    localparam logic [IDX_W-1:0] IX_CR3  = 6'h22;
    localparam logic [IDX_W-1:0] IX_CR4  = 6'h23;
    localparam logic [IDX_W-1:0] IX_FCR  = 6'h24;
    localparam logic [IDX_W-1:0] IX_SR1  = 6'h25;
    localparam logic [IDX_W-1:0] IX_SR2  = 6'h26;
    localparam logic [IDX_W-1:0] IX_BINC = 6'h29;
    localparam logic [IDX_W-1:0] IX_BMOD = 6'h2A;
    localparam logic [IDX_W-1:0] IX_BCNT = 6'h2B;
    localparam logic [IDX_W-1:0] IX_MSEC = 6'h2C;
    localparam logic [IDX_W-1:0] IX_TEST = 6'h2D;

    // bit positions
    localparam int S1_TRDY = 13, S1_RRDY = 9, S1_RTSS = 14, S1_RXDS = 6;
    localparam int S2_RDR = 0, S2_TXFE = 14, S2_TXDC = 3, S2_DCDIN = 5;
    localparam int C1_TXMPTYEN = 6, C1_RRDYEN = 9, C1_TRDYEN = 13;
    localparam int C2_SRST = 0, C2_TXEN = 2;
    localparam int T_TXEMPTY = 6, T_RXEMPTY = 5;
    localparam int RD_CHARRDY = 15, RD_ERR = 14, RD_BRK = 11;

    // reset and marker values
    localparam logic [REG_W-1:0] ERR_MARK  = REG_W'(1) << RD_ERR;
    localparam logic [REG_W-1:0] BRK_MARK  = REG_W'(1) << RD_BRK;
    localparam logic [REG_W-1:0] CR2_RST   = REG_W'(1) << C2_SRST;
    localparam logic [REG_W-1:0] CR3_RST   = 16'h0700;
    localparam logic [REG_W-1:0] BCNT_RST  = 16'h0004;
    localparam logic [REG_W-1:0] IRQ_SRC   = (REG_W'(1) << S1_TRDY) | (REG_W'(1) << S1_RRDY);
endpackage

// File: rtl/srf_rx_hold.sv
// Module: single-character receive holding buffer with full flag.
// Takes a character from the engine only while empty; a break loads a
// fixed marker. A read strobe empties it. Assumes clr is a one-cycle
// soft reset that outranks everything else.
module srf_rx_hold
    import srf_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic             rx_break,
    input  logic             take,
    output logic             rx_accept,
    output logic             full,
    output logic [REG_W-1:0] hold
);
    // handshake: accept only into an empty buffer, never during soft reset
    assign rx_accept = rx_valid && !full && !clr;

    // buffer and flag update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            full <= 1'b0;
            hold <= ERR_MARK;
        end else if (rx_accept) begin
            full <= 1'b1;
            hold <= rx_break ? BRK_MARK : REG_W'(rx_data);
        end else if (take && full) begin
            full <= 1'b0;
        end
    end

    p_accept_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_accept |=> full);
    p_read_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && full && !clr) |=> !full);
    p_held_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take && !clr) |=> (full && $stable(hold)));
endmodule

// File: rtl/srf_tx_hand.sv
// Module: one-character transmit hand-off toward the serial engine.
// A send with enable high loads the character and raises tx_valid until
// tx_ready; sends while busy or disabled are dropped.
module srf_tx_hand #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              send,
    input  logic              enable,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data
);
    // offer register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
        end else if (send && enable && !tx_valid) begin
            tx_valid <= 1'b1;
            tx_data  <= char_in;
        end
    end

    p_offer_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !clr) |=> (tx_valid && $stable(tx_data)));
    p_no_send_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && !(send && enable)) |=> !tx_valid);
endmodule

// File: rtl/srf_irq_combine.sv
// Module: interrupt combine from status 1, control 1 and test words.
// Purely combinational; assumes the inputs are registered upstream.
module srf_irq_combine
    import srf_pkg::*;
(
    input  logic [REG_W-1:0] sr1,
    input  logic [REG_W-1:0] cr1,
    input  logic [REG_W-1:0] tst,
    output logic             irq
);
    logic [REG_W-1:0] src;

    // mask, then gate the ready term by the tx-empty enable
    always_comb begin
        src = sr1 & cr1 & IRQ_SRC;
        if (cr1[C1_TXMPTYEN]) begin
            irq = (|src) || tst[T_TXEMPTY];
        end else begin
            src[S1_TRDY] = 1'b0;
            irq = |src;
        end
    end
endmodule

// File: rtl/serial_reg_front.sv
// Module: register front end of a serial port (top).
// Stores control, baud and FIFO settings, composes status/test words
// from the rx buffer and tx hand-off, and drives the interrupt.
// Assumes single-cycle bus strobes; read data appears one cycle later.
module serial_reg_front
    import srf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_break,
    output logic              rx_accept
);
    logic [REG_W-1:0] cr1_q, cr2_q, cr3_q, fcr_q, bmod_q, bcnt_q, msec_q;
    logic [REG_W-1:0] wlow, hold, sr1, sr2, tst, rd_mux;
    logic             soft_rst, rx_full, take, send;

    assign wlow     = wdata[REG_W-1:0];
    assign soft_rst = wr_en && (addr == IX_CR2) && !wdata[C2_SRST];
    assign take     = rd_en && (addr == IX_RXD);
    assign send     = wr_en && (addr == IX_TXD);

    srf_rx_hold #(.CHAR_W(CHAR_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
        .take(take), .rx_accept(rx_accept), .full(rx_full), .hold(hold)
    );

    srf_tx_hand #(.CHAR_W(CHAR_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .send(send), .enable(cr2_q[C2_TXEN]), .char_in(wdata[CHAR_W-1:0]),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
    );

    // status and test words composed from live state
    always_comb begin
        sr1 = '0;
        sr1[S1_RTSS] = 1'b1;
        sr1[S1_RXDS] = 1'b1;
        sr1[S1_TRDY] = !tx_valid;
        sr1[S1_RRDY] = rx_full;
        sr2 = '0;
        sr2[S2_TXFE]  = 1'b1;
        sr2[S2_TXDC]  = 1'b1;
        sr2[S2_DCDIN] = 1'b1;
        sr2[S2_RDR]   = rx_full;
        tst = '0;
        tst[T_TXEMPTY] = 1'b1;
        tst[T_RXEMPTY] = !rx_full;
    end

    srf_irq_combine u_irq (.sr1(sr1), .cr1(cr1_q), .tst(tst), .irq(irq));

    // stored registers: masked writes and soft reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr1_q  <= '0;
            cr2_q  <= CR2_RST;
            cr3_q  <= CR3_RST;
            fcr_q  <= '0;
            bmod_q <= '0;
            bcnt_q <= BCNT_RST;
            msec_q <= '0;
        end else if (wr_en) begin
            case (addr)
                IX_CR1:  cr1_q  <= wlow;
                IX_CR2: begin
                    if (soft_rst) begin
                        cr1_q  <= '0;
                        cr3_q  <= CR3_RST;
                        bmod_q <= '0;
                        bcnt_q <= BCNT_RST;
                    end
                    cr2_q <= wlow | CR2_RST;
                end
                IX_CR3:  cr3_q  <= wlow;
                IX_FCR:  fcr_q  <= wlow;
                IX_BMOD: bmod_q <= wlow;
                IX_MSEC: msec_q <= wlow;
                IX_BINC: bcnt_q <= wlow;
                default: ;
            endcase
        end
    end

    // read multiplexer
    always_comb begin
        case (addr)
            IX_RXD:  rd_mux = rx_full ? (hold | (REG_W'(1) << RD_CHARRDY)) : hold;
            IX_CR1:  rd_mux = cr1_q;
            IX_CR2:  rd_mux = cr2_q;
            IX_CR3:  rd_mux = cr3_q;
            IX_FCR:  rd_mux = fcr_q;
            IX_SR1:  rd_mux = sr1;
            IX_SR2:  rd_mux = sr2;
            IX_BMOD: rd_mux = bmod_q;
            IX_BCNT: rd_mux = bcnt_q;
            IX_MSEC: rd_mux = msec_q;
            IX_TEST: rd_mux = tst;
            default: rd_mux = '0;
        endcase
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_en)  rdata <= DATA_W'(rd_mux);
    end

    p_srst_reads_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cr2_q[C2_SRST]);
    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cr1_q[C1_TXMPTYEN] && !cr1_q[C1_RRDYEN]) |-> !irq);
    p_irq_txempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cr1_q[C1_TXMPTYEN] |-> irq);
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/test_serial_reg_front.sv
module test_serial_reg_front;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [5:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic        irq, tx_valid, tx_ready = 0, rx_valid = 0, rx_break = 0, rx_accept;
    logic [7:0]  tx_data, rx_data = 0;
    int          n_vec = 0, n_bad = 0;
    bit          done = 0;

    always #2 clk = ~clk;   // 250 MHz

    serial_reg_front i_serial_reg_front (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_break(rx_break), .rx_accept(rx_accept)
    );

    // {is_read, req, index, data-or-expected}
    localparam int NV = 47;
    localparam logic [42:0] VT [NV] = '{
        {1'b1,4'd1,6'h20,32'h0}, {1'b1,4'd1,6'h21,32'h1}, {1'b1,4'd1,6'h22,32'h700},      // R1
        {1'b1,4'd1,6'h25,32'h6040}, {1'b1,4'd1,6'h26,32'h4028}, {1'b1,4'd1,6'h2B,32'h4}, // R1
        {1'b1,4'd1,6'h2D,32'h60}, {1'b1,4'd1,6'h00,32'h4000}, {1'b1,4'd2,6'h23,32'h0},
        {1'b1,4'd1,6'h24,32'h0},
        {1'b0,4'd2,6'h22,32'hABCD1234}, {1'b1,4'd2,6'h22,32'h1234},                    // R2
        {1'b0,4'd2,6'h24,32'hFFFF0081}, {1'b1,4'd2,6'h24,32'h81},
        {1'b0,4'd2,6'h2A,32'h12345678}, {1'b1,4'd2,6'h2A,32'h5678},
        {1'b0,4'd2,6'h2C,32'h000103E8}, {1'b1,4'd2,6'h2C,32'h3E8},
        {1'b0,4'd2,6'h29,32'h0009000F}, {1'b1,4'd2,6'h2B,32'hF}, {1'b1,4'd2,6'h29,32'h0},
        {1'b0,4'd3,6'h23,32'hFFFF}, {1'b1,4'd3,6'h23,32'h0},                           // R3
        {1'b0,4'd10,6'h25,32'hFFFFFFFF}, {1'b1,4'd10,6'h25,32'h6040},                  // R10
        {1'b0,4'd10,6'h26,32'hFFFFFFFF}, {1'b1,4'd10,6'h26,32'h4028},
        {1'b0,4'd3,6'h2D,32'h0}, {1'b1,4'd3,6'h2D,32'h60},
        {1'b0,4'd3,6'h2B,32'h55}, {1'b1,4'd3,6'h2B,32'hF},
        {1'b0,4'd3,6'h30,32'h1234}, {1'b1,4'd3,6'h30,32'h0},
        {1'b0,4'd2,6'h21,32'h7}, {1'b1,4'd2,6'h21,32'h7},
        {1'b0,4'd2,6'h20,32'h00010041}, {1'b1,4'd2,6'h20,32'h41},
        {1'b0,4'd4,6'h21,32'h6}, {1'b1,4'd4,6'h21,32'h7},                              // R4
        {1'b1,4'd4,6'h20,32'h0}, {1'b1,4'd4,6'h22,32'h700}, {1'b1,4'd4,6'h2A,32'h0},
        {1'b1,4'd4,6'h2B,32'h4}, {1'b1,4'd4,6'h24,32'h81}, {1'b1,4'd4,6'h2C,32'h3E8},
        {1'b1,4'd6,6'h00,32'h4000}, {1'b1,4'd6,6'h2D,32'h60}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    task automatic rx_offer(input logic [7:0] c, input logic brk);
        @(negedge clk); rx_valid = 1; rx_data = c; rx_break = brk;
        @(negedge clk); rx_valid = 0; rx_break = 0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VT[i][42]) begin
                bus_rd(VT[i][37:32], v);
                chk($sformatf("R%0d row %0d", VT[i][41:38], i), v, VT[i][31:0]);
            end else begin
                bus_wr(VT[i][37:32], VT[i][31:0]);
            end
        end
        // R8 receive-ready enable, nothing held
        bus_wr(6'h20, 32'h0200);
        chk("R8 idle", {31'b0, irq}, 32'h0);
        // R5 accept into empty buffer
        @(negedge clk); rx_valid = 1; rx_data = 8'h41; #1;
        chk("R5 accept high", {31'b0, rx_accept}, 32'h1);
        @(negedge clk); #1;
        chk("R5 second refused", {31'b0, rx_accept}, 32'h0);
        @(negedge clk); rx_valid = 0;
        chk("R8 rx irq", {31'b0, irq}, 32'h1);
        bus_rd(6'h25, v); chk("R5 status1", v, 32'h6240);
        bus_rd(6'h26, v); chk("R5 status2", v, 32'h4029);
        bus_rd(6'h2D, v); chk("R5 test", v, 32'h40);
        // R6 read-clear
        bus_rd(6'h00, v); chk("R6 first read", v, 32'h8041);
        chk("R8 irq cleared", {31'b0, irq}, 32'h0);
        bus_rd(6'h00, v); chk("R6 empty read", v, 32'h41);
        bus_rd(6'h2D, v); chk("R6 test", v, 32'h60);
        // R11 hold across idle cycles
        repeat (3) @(negedge clk);
        chk("R11 hold", rdata, 32'h60);
        bus_wr(6'h22, 32'h5);
        chk("R11 hold after write", rdata, 32'h60);
        // R7 break
        rx_offer(8'h55, 1'b1);
        bus_rd(6'h00, v); chk("R7 break", v, 32'h8800);
        // R4 soft reset empties a held character
        rx_offer(8'h33, 1'b0);
        bus_wr(6'h21, 32'h4);
        bus_rd(6'h2D, v); chk("R4 rx emptied", v, 32'h60);
        bus_rd(6'h00, v); chk("R4 buffer marker", v, 32'h4000);
        // R8 truth table
        bus_wr(6'h20, 32'h2000); chk("R8 trdy w/o txmpty", {31'b0, irq}, 32'h0);
        bus_wr(6'h20, 32'h2040); chk("R8 trdy+txmpty", {31'b0, irq}, 32'h1);
        bus_wr(6'h20, 32'h0040); chk("R8 txmpty only", {31'b0, irq}, 32'h1);
        bus_wr(6'h20, 32'h0000); chk("R8 none", {31'b0, irq}, 32'h0);
        // R9 transmit hand-off (control 2 = 0x5 : TXEN)
        bus_wr(6'h21, 32'h5);
        bus_wr(6'h10, 32'h15A);
        chk("R9 valid", {31'b0, tx_valid}, 32'h1);
        chk("R9 data", {24'b0, tx_data}, 32'h5A);
        bus_rd(6'h25, v); chk("R9 trdy low", v, 32'h4040);
        @(negedge clk); tx_ready = 1;
        @(negedge clk); tx_ready = 0;
        chk("R9 released", {31'b0, tx_valid}, 32'h0);
        bus_rd(6'h25, v); chk("R9 trdy back", v, 32'h6040);
        bus_wr(6'h21, 32'h1);
        bus_wr(6'h10, 32'h77);
        chk("R9 disabled", {31'b0, tx_valid}, 32'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule